// File: doc/BRIEF.md
# Daisy-Chain SPI Command Frame Encoder

This block sits on the host side of a serial link that feeds a chain of chips. Host logic hands it one command at a time: a one-byte control token, a repeated token, or a data write with a 16-bit word address and a payload of 32-bit words. The block turns each accepted command into bytes and shifts them out as an SPI mode 0 master, eight bits per word, most significant bit first. Each byte the chain returns on MISO is presented with a one-cycle strobe.

Commands are grouped into frames. The first command offered while idle opens a frame. Before chip select drops, the block plays a chain-reset pattern: SCK is held high while MOSI pulses. Chip select then stays low until an end command closes the frame. After that, chip select rises and the reset pattern plays again. A running byte total guards the frame's size limit. Requests that are malformed, or that would push the total to the limit, are taken off the interface and produce no bytes.

Top module: `spi_chain_encoder`

## Requirements
- R1: Command codes on cmdOp are 0 = break, 1 = fsync, 2 = fasync, 3 = nop, 4 = write, 5 = end. A break sends the byte 0x04, an fsync sends 0x06, each fasync copy sends 0x05 and each nop copy sends 0x00.
- R2: fasync and nop send cmdCount copies of their byte back to back. A count of zero sends nothing.
- R3: For a write, cmdCount is the payload length in bytes. It is accepted only from 4 to 128 inclusive, and the word count is cmdCount divided by 4, rounded down. Any other length sends nothing.
- R4: A write starts with three unreversed bytes: 0xE0 OR (word count - 1), then cmdAddr[15:8], then cmdAddr[7:0].
- R5: Each payload word is taken from the word port. Its bytes go out lowest byte first (wordData[7:0] first), and each byte is bit-reversed before shifting, so its bit 0 is the first bit on the wire.
- R6: SPI mode 0. SCK idles low, MOSI changes only while SCK is low, and MISO is sampled on the rising edge. Each SCK phase lasts sckDiv clock cycles, and a value of 0 acts as 1.
- R7: Opening a frame plays 32 MOSI pulses while SCK is held high and csN is high. Each level lasts RST_HALF cycles. SCK and MOSI are both low afterwards, and only then does csN fall.
- R8: The end command raises csN and then plays the same 32-pulse pattern before busy falls.
- R9: A command whose byte count, added to the bytes already accepted in the frame, would reach MAX_FRAME (default 160) sends nothing. The total restarts at zero in each frame.
- R10: After reset, csN is high, SCK and MOSI are low, and busy and cmdReady are low. cmdReady is high only while csN is low, and busy is high from the frame's opening to the end of its closing pattern.
- R11: After the eighth rising SCK edge of a byte, rxValid pulses for one cycle with rxData holding the eight MISO samples, the first one in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sckDiv | input | 8 | SCK half period in clock cycles (0 treated as 1) |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Command taken this cycle |
| cmdOp | input | 3 | Command code |
| cmdCount | input | 8 | Repeat count, or payload length in bytes for a write |
| cmdAddr | input | 16 | Word address for a write |
| wordValid | input | 1 | Payload word offered |
| wordReady | output | 1 | Payload word taken this cycle |
| wordData | input | 32 | Payload word |
| busy | output | 1 | Frame in progress |
| csN | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| rxValid | output | 1 | Received byte strobe |
| rxData | output | 8 | Received byte |

## Verification
The bench aims at the write length edges: 3 and 129 bytes, and 7 bytes, which has to be rounded down to one word. An engine with a wrong bound, or one that does not truncate, sends extra bytes or a wrong count in the header. It fills a frame to one byte below the limit and then offers one more token. An off-by-one in the limit test either drops the break or lets that token through. It also checks the zero repeat count, a divider of zero, the payload bit reversal next to unreversed header bytes, and the pulse count and width of both reset patterns. A design that reverses the wrong bytes, swaps the word byte order or miscounts pulses shows up as a byte or count mismatch.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

  typedef enum logic [2:0] {
    OP_BREAK  = 3'd0,
    OP_FSYNC  = 3'd1,
    OP_FASYNC = 3'd2,
    OP_NOP    = 3'd3,
    OP_WRITE  = 3'd4,
    OP_END    = 3'd5
  } chainOpT;

  typedef struct packed {
    logic       loadByte;
    logic [7:0] byteVal;
    logic       startRst;
  } dpCtrlT;

  function automatic logic [7:0] flipByte(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

endpackage

// File: rtl/chain_dp.sv
module chain_dp
  import spi_chain_pkg::*;
#(
  parameter int RST_HALF   = 125,
  parameter int RST_PULSES = 32,
  parameter int DIV_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrlT           ctl,
  input  logic [DIV_W-1:0] sckDiv,
  input  logic             miso,
  output logic             sckOut,
  output logic             mosiOut,
  output logic             byteBusy,
  output logic             rstBusy,
  output logic             rxValid,
  output logic [7:0]       rxData
);
  localparam int RC_W = $clog2(RST_HALF) + 1;
  localparam int PC_W = $clog2(RST_PULSES) + 1;

  logic [DIV_W-1:0] divCnt, halfLim;
  logic [7:0] txSh, rxSh;
  logic [2:0] bitCnt;
  logic sckInt;
  logic [RC_W-1:0] rstCnt;
  logic [PC_W-1:0] pulseCnt;
  logic rstLvl;

  assign halfLim = (sckDiv == '0) ? DIV_W'(1) : sckDiv;

  // byte shifter, mode 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteBusy <= 1'b0; txSh <= '0; rxSh <= '0; bitCnt <= '0;
      divCnt <= '0; sckInt <= 1'b0; rxValid <= 1'b0; rxData <= '0;
    end else begin
      rxValid <= 1'b0;
      if (ctl.loadByte) begin
        byteBusy <= 1'b1; txSh <= ctl.byteVal; bitCnt <= '0;
        divCnt <= '0; sckInt <= 1'b0;
      end else if (byteBusy) begin
        if (divCnt == halfLim - 1'b1) begin
          divCnt <= '0;
          if (!sckInt) begin
            sckInt <= 1'b1;
            rxSh <= {rxSh[6:0], miso};
          end else begin
            sckInt <= 1'b0;
            if (bitCnt == 3'd7) begin
              byteBusy <= 1'b0; rxValid <= 1'b1; rxData <= rxSh;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              txSh <= {txSh[6:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
      if (ctl.startRst) txSh <= '0;
    end
  end

  // chain reset pattern: SCK high, MOSI pulsing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstBusy <= 1'b0; rstLvl <= 1'b0; rstCnt <= '0; pulseCnt <= '0;
    end else if (ctl.startRst) begin
      rstBusy <= 1'b1; rstLvl <= 1'b1; rstCnt <= '0; pulseCnt <= '0;
    end else if (rstBusy) begin
      if (rstCnt == RC_W'(RST_HALF - 1)) begin
        rstCnt <= '0;
        if (rstLvl) begin
          rstLvl <= 1'b0;
          pulseCnt <= pulseCnt + 1'b1;
        end else if (pulseCnt == PC_W'(RST_PULSES)) begin
          rstBusy <= 1'b0;
        end else begin
          rstLvl <= 1'b1;
        end
      end else begin
        rstCnt <= rstCnt + 1'b1;
      end
    end
  end

  assign sckOut  = rstBusy | sckInt;
  assign mosiOut = rstBusy ? rstLvl : txSh[7];

  // R6: data never moves on a rising serial clock edge
  p_mosi_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sckOut) && !rstBusy) |-> $stable(mosiOut));
  // R7: pulse count never runs past the programmed number
  p_pulse_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PC_W'(RST_PULSES));
endmodule

// File: rtl/chain_ctrl.sv
module chain_ctrl
  import spi_chain_pkg::*;
#(
  parameter int MAX_FRAME = 160
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  input  logic [7:0]  cmdCount,
  input  logic [15:0] cmdAddr,
  input  logic        wordValid,
  input  logic [31:0] wordData,
  input  logic        byteBusy,
  input  logic        rstBusy,
  output logic        cmdReady,
  output logic        wordReady,
  output logic        csN,
  output logic        busy,
  output dpCtrlT      ctl
);
  localparam int FB_W = $clog2(MAX_FRAME + 512);
  localparam logic [FB_W-1:0] MAX_F = FB_W'(MAX_FRAME);

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_OPEN, S_LOAD, S_WAITB, S_WORD, S_GAP, S_POST
  } stateT;

  stateT state;
  chainOpT op, curOp;
  logic [FB_W-1:0] frameBytes, reqBytes;
  logic [7:0] seqPos, seqLen, nextPos, posM3;
  logic [15:0] addrReg;
  logic [4:0] wordsM1;
  logic [31:0] wordReg;
  logic lenOk, fits;
  logic [7:0] curByte;

  assign op = chainOpT'(cmdOp);

  always_comb begin
    case (op)
      OP_BREAK, OP_FSYNC:  reqBytes = FB_W'(1);
      OP_FASYNC, OP_NOP:   reqBytes = FB_W'(cmdCount);
      OP_WRITE:            reqBytes = FB_W'(3) + FB_W'({cmdCount[7:2], 2'b00});
      default:             reqBytes = '0;
    endcase
  end
  assign lenOk = (op != OP_WRITE) || (cmdCount >= 8'd4 && cmdCount <= 8'd128);
  assign fits  = (frameBytes + reqBytes) < MAX_F;

  assign nextPos = seqPos + 1'b1;
  assign posM3   = seqPos - 8'd3;

  always_comb begin
    case (curOp)
      OP_BREAK:  curByte = 8'h04;
      OP_FSYNC:  curByte = 8'h06;
      OP_FASYNC: curByte = 8'h05;
      OP_WRITE: begin
        if (seqPos == 8'd0)      curByte = {3'b111, wordsM1};
        else if (seqPos == 8'd1) curByte = addrReg[15:8];
        else if (seqPos == 8'd2) curByte = addrReg[7:0];
        else                     curByte = flipByte(wordReg[posM3[1:0]*8 +: 8]);
      end
      default:   curByte = 8'h00;
    endcase
  end

  assign cmdReady  = (state == S_OPEN);
  assign wordReady = (state == S_WORD);
  assign busy      = (state != S_IDLE);

  always_comb begin
    ctl = '0;
    ctl.loadByte = (state == S_LOAD);
    ctl.byteVal  = curByte;
    ctl.startRst = (state == S_IDLE && cmdValid) || (state == S_GAP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; csN <= 1'b1; frameBytes <= '0; curOp <= OP_NOP;
      seqPos <= '0; seqLen <= '0; addrReg <= '0; wordsM1 <= '0; wordReg <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmdValid) state <= S_PRE;
        S_PRE: if (!rstBusy) begin csN <= 1'b0; state <= S_OPEN; end
        S_OPEN: if (cmdValid) begin
          if (op == OP_END) begin
            csN <= 1'b1; frameBytes <= '0; state <= S_GAP;
          end else if (lenOk && fits && reqBytes != '0) begin
            frameBytes <= frameBytes + reqBytes;
            curOp   <= op;
            seqPos  <= '0;
            seqLen  <= reqBytes[7:0];
            addrReg <= cmdAddr;
            wordsM1 <= 5'(cmdCount[7:2] - 6'd1);
            state   <= S_LOAD;
          end
        end
        S_LOAD: state <= S_WAITB;
        S_WAITB: if (!byteBusy) begin
          seqPos <= nextPos;
          if (nextPos == seqLen) state <= S_OPEN;
          else if (curOp == OP_WRITE && nextPos >= 8'd3 && nextPos[1:0] == 2'd3)
            state <= S_WORD;
          else state <= S_LOAD;
        end
        S_WORD: if (wordValid) begin wordReg <= wordData; state <= S_LOAD; end
        S_GAP: state <= S_POST;
        S_POST: if (!rstBusy) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6: a byte is loaded only into an idle shifter
  p_load_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadByte |-> (!byteBusy && !rstBusy));
  // R9: the accepted total stays under the limit
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    frameBytes < MAX_F);
  // R7: chip select stays high while the reset pattern plays
  p_cs_in_reset_r7: assert property (@(posedge clk) disable iff (!rstN)
    rstBusy |-> csN);
  // R10: commands are taken only inside an open frame
  p_ready_cs_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !csN);
endmodule

// File: rtl/spi_chain_encoder.sv
module spi_chain_encoder
  import spi_chain_pkg::*;
#(
  parameter int MAX_FRAME  = 160,
  parameter int RST_HALF   = 125,
  parameter int RST_PULSES = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  sckDiv,
  input  logic        cmdValid,
  output logic        cmdReady,
  input  logic [2:0]  cmdOp,
  input  logic [7:0]  cmdCount,
  input  logic [15:0] cmdAddr,
  input  logic        wordValid,
  output logic        wordReady,
  input  logic [31:0] wordData,
  output logic        busy,
  output logic        csN,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        rxValid,
  output logic [7:0]  rxData
);
  dpCtrlT ctl;
  logic byteBusy, rstBusy;

  chain_ctrl #(.MAX_FRAME(MAX_FRAME)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdCount(cmdCount), .cmdAddr(cmdAddr), .wordValid(wordValid),
    .wordData(wordData), .byteBusy(byteBusy), .rstBusy(rstBusy),
    .cmdReady(cmdReady), .wordReady(wordReady), .csN(csN), .busy(busy),
    .ctl(ctl)
  );

  chain_dp #(.RST_HALF(RST_HALF), .RST_PULSES(RST_PULSES), .DIV_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sckDiv(sckDiv), .miso(miso),
    .sckOut(sck), .mosiOut(mosi), .byteBusy(byteBusy), .rstBusy(rstBusy),
    .rxValid(rxValid), .rxData(rxData)
  );
endmodule

// File: tb/spi_chain_encoder_test.sv
module spi_chain_encoder_test;
  localparam int RH = 6;
  localparam int MAXF = 160;

  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0] sckDiv = 8'd0;
  logic cmdValid = 1'b0, cmdReady;
  logic [2:0] cmdOp = 3'd0;
  logic [7:0] cmdCount = 8'd0;
  logic [15:0] cmdAddr = 16'd0;
  logic wordValid, wordReady;
  logic [31:0] wordData;
  logic busy, csN, sck, mosi, miso, rxValid;
  logic [7:0] rxData;

  always #2 clk = ~clk;
  assign miso = mosi;

  spi_chain_encoder #(.MAX_FRAME(MAXF), .RST_HALF(RH)) uut (
    .clk(clk), .rstN(rstN), .sckDiv(sckDiv), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdCount(cmdCount), .cmdAddr(cmdAddr),
    .wordValid(wordValid), .wordReady(wordReady), .wordData(wordData),
    .busy(busy), .csN(csN), .sck(sck), .mosi(mosi), .miso(miso),
    .rxValid(rxValid), .rxData(rxData)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;
  logic [7:0] expQ[$], txQ[$], rxQ[$];
  string reqQ[$];
  int expTotal = 0, expWord = 0, feedIdx = 0;
  int rstRise = 0, rstHigh = 0, sckHigh = 0;
  logic prevMosi = 1'b0, accPend = 1'b0;
  logic [7:0] capSh = 8'd0;
  int capN = 0;

  function automatic logic [31:0] pat(input int i);
    return 32'hA5C3_0F81 + 32'(i) * 32'h0102_0304;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = b[i];
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // word feeder
  initial begin
    wordValid = 1'b1;
    wordData = pat(0);
    forever begin
      @(negedge clk);
      if (accPend) begin feedIdx++; wordData = pat(feedIdx); end
      accPend = wordReady;
    end
  end

  // monitors
  always @(posedge sck) begin
    if (!csN) begin
      capSh = {capSh[6:0], mosi};
      capN++;
      if (capN == 8) begin txQ.push_back(capSh); capN = 0; end
    end
  end
  always @(negedge clk) begin
    if (rxValid) rxQ.push_back(rxData);
    if (csN && sck && mosi && !prevMosi) rstRise++;
    if (csN && sck && mosi) rstHigh++;
    if (!csN && sck) sckHigh++;
    prevMosi = mosi;
  end

  // expected bytes, from the requirements
  task automatic expect_cmd(input logic [2:0] op, input logic [7:0] cnt, input logic [15:0] addr);
    int n, w;
    case (op)
      3'd0, 3'd1: n = 1;
      3'd2, 3'd3: n = cnt;
      3'd4: begin
        if (cnt < 4 || cnt > 128) return;  // R3
        w = cnt / 4;
        n = 3 + 4 * w;
      end
      default: return;
    endcase
    if (expTotal + n >= MAXF) return;      // R9
    expTotal += n;
    case (op)
      3'd0: begin expQ.push_back(8'h04); reqQ.push_back("R1 break"); end
      3'd1: begin expQ.push_back(8'h06); reqQ.push_back("R1 fsync"); end
      3'd2: for (int i = 0; i < n; i++) begin expQ.push_back(8'h05); reqQ.push_back("R2 fasync"); end
      3'd3: for (int i = 0; i < n; i++) begin expQ.push_back(8'h00); reqQ.push_back("R2 nop"); end
      default: begin
        expQ.push_back(8'hE0 | 8'(w - 1)); reqQ.push_back("R4 header");
        expQ.push_back(addr[15:8]); reqQ.push_back("R4 addr hi");
        expQ.push_back(addr[7:0]); reqQ.push_back("R4 addr lo");
        for (int k = 0; k < w; k++) begin
          logic [31:0] d;
          d = pat(expWord);
          expWord++;
          for (int b = 0; b < 4; b++) begin
            expQ.push_back(rev8(d[b*8 +: 8])); reqQ.push_back("R5 payload");
          end
        end
      end
    endcase
  endtask

  task automatic send(input logic [2:0] op, input logic [7:0] cnt, input logic [15:0] addr);
    if (op != 3'd5) expect_cmd(op, cnt, addr);
    @(negedge clk);
    cmdOp = op; cmdCount = cnt; cmdAddr = addr; cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic open_frame();
    rstRise = 0; rstHigh = 0; sckHigh = 0; expTotal = 0;
    expQ.delete(); txQ.delete(); rxQ.delete(); reqQ.delete();
  endtask

  task automatic close_frame(input int expSckHigh);
    send(3'd5, 8'd0, 16'd0);
    while (busy) @(negedge clk);
    check("R8 pulse total", rstRise, 64);
    check("R8 high cycles", rstHigh, 64 * RH);
    check("R7 sck low after pattern", int'(sck), 0);
    check("R7 mosi low after pattern", int'(mosi), 0);
    check("R10 csN high after frame", int'(csN), 1);
    check("R2 byte count", txQ.size(), expQ.size());
    check("R11 rx count", rxQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < txQ.size(); i++)
      check(reqQ[i], txQ[i], expQ[i]);
    for (int i = 0; i < expQ.size() && i < rxQ.size(); i++)
      check("R11 rx byte", rxQ[i], expQ[i]);
    if (expSckHigh >= 0) check("R6 sck high cycles", sckHigh, expSckHigh);
  endtask

  // {op, count, addr}
  localparam logic [26:0] VEC [10] = '{
    {3'd0, 8'd0,   16'h0000},
    {3'd1, 8'd0,   16'h0000},
    {3'd2, 8'd3,   16'h0000},
    {3'd3, 8'd2,   16'h0000},
    {3'd4, 8'd8,   16'h1234},
    {3'd4, 8'd3,   16'h5555},
    {3'd4, 8'd129, 16'h6666},
    {3'd2, 8'd0,   16'h0000},
    {3'd4, 8'd7,   16'hABCD},
    {3'd3, 8'd1,   16'h0000}
  };

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 csN", int'(csN), 1);
    check("R10 sck", int'(sck), 0);
    check("R10 mosi", int'(mosi), 0);
    check("R10 busy", int'(busy), 0);
    check("R10 cmdReady", int'(cmdReady), 0);
    rstN = 1'b1;
    @(negedge clk);

    // frame A: table walk, sckDiv 0 acts as 1 (R6)
    sckDiv = 8'd0;
    open_frame();
    for (int v = 0; v < 10; v++) begin
      send(VEC[v][26:24], VEC[v][23:16], VEC[v][15:0]);
      if (v == 0) begin
        check("R7 pre pulses", rstRise, 32);
        check("R7 pre high cycles", rstHigh, 32 * RH);
        check("R10 busy in frame", int'(busy), 1);
      end
    end
    while (cmdReady == 1'b0) @(negedge clk);
    close_frame(26 * 8);

    // frame C: fill to one below the limit, next token dropped (R9)
    sckDiv = 8'd1;
    open_frame();
    send(3'd3, 8'd158, 16'd0);
    send(3'd0, 8'd0, 16'd0);
    send(3'd1, 8'd0, 16'd0);
    while (cmdReady == 1'b0) @(negedge clk);
    close_frame(159 * 8);
    check("R9 frame at limit-1", expTotal, 159);

    // frame B: fresh total, slower clock (R6, R9)
    sckDiv = 8'd3;
    open_frame();
    send(3'd0, 8'd0, 16'd0);
    while (cmdReady == 1'b0) @(negedge clk);
    close_frame(8 * 3);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule